// File: doc/BRIEF.md
# Programmable Serial Flash Command Sequencer

This block runs a single serial-flash transaction as a chain of up to three phases: an opcode phase, an optional address phase, and an optional data phase that either drives bytes out of a write stream or gathers bytes into a read stream. Each phase independently runs on one, two or four data lines. Two configuration words are captured on `start`. The control word gives each phase's line width and says which phase follows the opcode and which follows the address. The length word gives the opcode and address phases a cycle count each. Dummy clocks are not a separate phase: they are the clocks of the address (or opcode) phase that remain once its bits are used up, and the data lines float during them.

The sequencer derives the serial clock from its own clock at half rate, in SPI mode 0. It drives chip select and the pad-side output and enable of four IO lines, and it reads the pad inputs. Write bytes arrive on a valid/ready stream. While no byte is offered the serial clock pauses low, and chip select stays asserted. Read bytes leave as one-cycle pulses on an output stream. A byte count, captured at start, ends the data phase.

Top module: `sflash_seq`

## Requirements
- R1: Width code 2'b00 or 2'b01 selects one line: bits go out on IO0 and come in on IO1. Code 2'b10 selects two lines (IO1 carries the earlier bit). Code 2'b11 selects four lines (IO3 carries the earliest bit). Width codes 0 and 1 behave identically.
- R2: The control word holds the data width in bits [1:0], the address width in [3:2], the opcode width in [5:4], the address successor in [7:6] and the opcode successor in [10:8]. Each width applies only to its own phase.
- R3: Opcode successor 3'b011 starts the address phase, 3'b101 starts a write-data phase, 3'b110 starts a read-data phase. Every other value ends the transaction after the opcode.
- R4: Address successor 2'b01 starts a write-data phase and 2'b10 starts a read-data phase. Successor 2'b00 or 2'b11 ends the transaction after the address.
- R5: The length word's bits [5:0] hold the address clock count minus one, and bits [11:6] hold the opcode clock count minus one. Each phase runs exactly that many serial clocks plus one.
- R6: The opcode (8 bits) and the address (24 bits) are shifted out MSB first. Once a phase's bits are exhausted, its remaining clocks are dummy clocks with all IO enables low.
- R7: During a read phase all IO enables are low. The sampled bits are packed MSB first, and each finished byte appears on `rd_data` with a one-cycle `rd_valid`.
- R8: Write bytes are taken from the stream one per byte slot and shifted out MSB first. While no byte is offered, `wr_ready` is high, the serial clock stays low and chip select stays low.
- R9: A data phase moves exactly `byte_cnt` bytes. A count of 0 moves one byte.
- R10: `cs_n` falls on the clock after `start` is taken, one clock before the first rising edge of `sck`. It rises one clock after the last falling edge of `sck`, together with a one-cycle `done`. `busy` is high from the start to that point. Reset leaves `cs_n` high and `sck`, `busy`, `done`, `wr_ready` and the IO enables low.
- R11: `sck` idles low and rises only while chip select is low. Outputs and enables change only while `sck` is low, and inputs are sampled on the clock where `sck` rises.
- R12: A `start` raised while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transaction (taken only when idle) |
| ctrl_word | input | 11 | Phase widths and successor codes |
| len_word | input | 12 | Opcode and address clock counts, minus one |
| opcode | input | 8 | Command byte |
| address | input | ADDR_W | Address value, sent MSB first |
| byte_cnt | input | CNT_W | Data bytes to move |
| wr_data | input | 8 | Write stream byte |
| wr_valid | input | 1 | Write stream byte offered |
| wr_ready | output | 1 | Sequencer waiting for a write byte |
| rd_data | output | 8 | Assembled read byte |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| cs_n | output | 1 | Chip select, active low |
| sck | output | 1 | Serial clock |
| io_out | output | 4 | Pad output values for IO3..IO0 |
| io_oe | output | 4 | Pad output enables for IO3..IO0 |
| io_in | input | 4 | Pad input values for IO3..IO0 |

## Verification
A corrupted phase counter or a wrong successor decode changes the number of serial clock edges in the frame. That shows in the edge total once chip select rises, and the first wrong edge already carries the wrong lane pattern or enable state. A shifter that is misaligned or shifts by the wrong lane count corrupts the first address or data bit after the fault, which is visible within one serial clock. A read assembler that loses its bit count misplaces every following byte, visible at the next `rd_valid`. Errors in chip-select or done timing show as a one-clock offset between the chip-select edges and the first or last `sck` edge.

// File: rtl/sfseq_pkg.sv
package sfseq_pkg;

   // control word field positions (decoded by the sequencer)
   localparam int CTRL_W   = 11;
   localparam int DW_LSB   = 0;
   localparam int AW_LSB   = 2;
   localparam int CW_LSB   = 4;
   localparam int ASUC_LSB = 6;
   localparam int CSUC_LSB = 8;
   // length word field positions
   localparam int LFLD_W   = 6;
   localparam int ALEN_LSB = 0;
   localparam int CLEN_LSB = 6;
   localparam int LEN_W    = 12;

   typedef enum logic [2:0] {
      ST_IDLE, ST_CMD, ST_ADDR, ST_WDAT, ST_RDAT, ST_TAIL
   } seq_st_e;

   function automatic logic [2:0] lane_cnt(input logic [1:0] code);
      case (code)
         2'd3:    return 3'd4;
         2'd2:    return 3'd2;
         default: return 3'd1;
      endcase
   endfunction

   function automatic logic [3:0] lane_mask(input logic [2:0] n);
      case (n)
         3'd4:    return 4'hF;
         3'd2:    return 4'h3;
         default: return 4'h1;
      endcase
   endfunction

   function automatic seq_st_e after_cmd(input logic [2:0] code);
      case (code)
         3'b011:  return ST_ADDR;
         3'b101:  return ST_WDAT;
         3'b110:  return ST_RDAT;
         default: return ST_TAIL;
      endcase
   endfunction

   function automatic seq_st_e after_addr(input logic [1:0] code);
      case (code)
         2'b01:   return ST_WDAT;
         2'b10:   return ST_RDAT;
         default: return ST_TAIL;
      endcase
   endfunction

endpackage

// File: rtl/sfseq_tx_shift.sv
module sfseq_tx_shift #(
   parameter int SR_W   = 24,
   parameter int BITS_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [SR_W-1:0]   load_val,
   input  logic [BITS_W-1:0] load_bits,
   input  logic              shift,
   input  logic [2:0]        lanes,
   output logic [3:0]        lane_out,
   output logic              active
);

   generate
      if (SR_W < 8) begin : g_bad_width
         $error("sfseq_tx_shift: SR_W must be at least 8");
      end
   endgenerate

   logic [SR_W-1:0]   sr;
   logic [BITS_W-1:0] left;
   logic [BITS_W-1:0] step;

   assign step = BITS_W'(lanes);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr   <= '0;
         left <= '0;
      end else if (load) begin
         sr   <= load_val;
         left <= load_bits;
      end else if (shift) begin
         sr   <= sr << lanes;
         left <= (left > step) ? left - step : '0;
      end
   end

   always_comb begin
      case (lanes)
         3'd4:    lane_out = sr[SR_W-1 -: 4];
         3'd2:    lane_out = {2'b00, sr[SR_W-1 -: 2]};
         default: lane_out = {3'b000, sr[SR_W-1]};
      endcase
   end

   assign active = (left != '0);

   // R6
   tx_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !load) |=> !active);

endmodule

// File: rtl/sfseq_rx_pack.sv
module sfseq_rx_pack (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       sample,
   input  logic [2:0] lanes,
   input  logic [3:0] io_in,
   output logic [7:0] byte_out,
   output logic       byte_valid
);

   logic [7:0] acc;
   logic [3:0] cnt;
   logic [3:0] bits_in;
   logic [7:0] nxt;

   always_comb begin
      case (lanes)
         3'd4:    bits_in = io_in;
         3'd2:    bits_in = {2'b00, io_in[1:0]};
         default: bits_in = {3'b000, io_in[1]};
      endcase
      nxt = (acc << lanes) | {4'h0, bits_in};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc        <= '0;
         cnt        <= '0;
         byte_out   <= '0;
         byte_valid <= 1'b0;
      end else begin
         byte_valid <= 1'b0;
         if (clr) begin
            cnt <= '0;
         end else if (sample) begin
            if (cnt + 4'(lanes) >= 4'd8) begin
               byte_out   <= nxt;
               byte_valid <= 1'b1;
               cnt        <= '0;
            end else begin
               cnt <= cnt + 4'(lanes);
            end
            acc <= nxt;
         end
      end
   end

   // R7
   rx_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid |-> $past(sample));

endmodule

// File: rtl/sflash_seq.sv
module sflash_seq
   import sfseq_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [10:0]       ctrl_word,
   input  logic [11:0]       len_word,
   input  logic [7:0]        opcode,
   input  logic [ADDR_W-1:0] address,
   input  logic [CNT_W-1:0]  byte_cnt,
   input  logic [7:0]        wr_data,
   input  logic              wr_valid,
   output logic              wr_ready,
   output logic [7:0]        rd_data,
   output logic              rd_valid,
   output logic              busy,
   output logic              done,
   output logic              cs_n,
   output logic              sck,
   output logic [3:0]        io_out,
   output logic [3:0]        io_oe,
   input  logic [3:0]        io_in
);

   localparam int BITS_W = $clog2(ADDR_W + 1);
   localparam int PAD_W  = ADDR_W - 8;

   generate
      if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr
         $error("sflash_seq: ADDR_W must lie in 8..32");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("sflash_seq: CNT_W must be positive");
      end
   endgenerate

   seq_st_e            st, phase_nxt;
   logic               h;
   logic [CTRL_W-1:0]  ctrl_q;
   logic [LEN_W-1:0]   len_q;
   logic [ADDR_W-1:0]  addr_q;
   logic [CNT_W-1:0]   cnt_q, bytes_left;
   logic [LFLD_W-1:0]  cyc;
   logic [3:0]         dbits;
   logic               have;

   logic [2:0] cw_n, aw_n, dw_n, cur_n;
   logic       phase_last, data_last, wr_take, start_ok;
   logic       sh_load, sh_shift, sh_active;
   logic [ADDR_W-1:0] sh_val;
   logic [BITS_W-1:0] sh_bits;
   logic [3:0]        sh_lanes;

   assign cw_n = lane_cnt(ctrl_q[CW_LSB +: 2]);
   assign aw_n = lane_cnt(ctrl_q[AW_LSB +: 2]);
   assign dw_n = lane_cnt(ctrl_q[DW_LSB +: 2]);

   always_comb begin
      case (st)
         ST_CMD:  cur_n = cw_n;
         ST_ADDR: cur_n = aw_n;
         default: cur_n = dw_n;
      endcase
   end

   assign start_ok   = start && (st == ST_IDLE);
   assign phase_last = h && (cyc == '0) && (st == ST_CMD || st == ST_ADDR);
   assign phase_nxt  = (st == ST_CMD) ? after_cmd(ctrl_q[CSUC_LSB +: 3])
                                      : after_addr(ctrl_q[ASUC_LSB +: 2]);
   assign data_last  = (dbits == 4'(dw_n));
   assign wr_ready   = (st == ST_WDAT) && !h && !have;
   assign wr_take    = wr_ready && wr_valid;

   // transmit shifter shared by opcode, address and write bytes
   always_comb begin
      sh_load = 1'b0;
      sh_val  = {wr_data, {PAD_W{1'b0}}};
      sh_bits = BITS_W'(8);
      if (start_ok) begin
         sh_load = 1'b1;
         sh_val  = {opcode, {PAD_W{1'b0}}};
      end else if (phase_last && st == ST_CMD && phase_nxt == ST_ADDR) begin
         sh_load = 1'b1;
         sh_val  = addr_q;
         sh_bits = BITS_W'(ADDR_W);
      end else if (wr_take) begin
         sh_load = 1'b1;
      end
   end

   assign sh_shift = h && (st == ST_CMD || st == ST_ADDR || st == ST_WDAT);

   sfseq_tx_shift #(.SR_W(ADDR_W), .BITS_W(BITS_W)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (sh_load),
      .load_val (sh_val),
      .load_bits(sh_bits),
      .shift    (sh_shift),
      .lanes    (cur_n),
      .lane_out (sh_lanes),
      .active   (sh_active)
   );

   sfseq_rx_pack u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (start_ok),
      .sample    ((st == ST_RDAT) && !h),
      .lanes     (dw_n),
      .io_in     (io_in),
      .byte_out  (rd_data),
      .byte_valid(rd_valid)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         h          <= 1'b0;
         cs_n       <= 1'b1;
         done       <= 1'b0;
         ctrl_q     <= '0;
         len_q      <= '0;
         addr_q     <= '0;
         cnt_q      <= '0;
         bytes_left <= '0;
         cyc        <= '0;
         dbits      <= '0;
         have       <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st)
            ST_IDLE: if (start) begin
               ctrl_q <= ctrl_word;
               len_q  <= len_word;
               addr_q <= address;
               cnt_q  <= byte_cnt;
               cyc    <= len_word[CLEN_LSB +: LFLD_W];
               cs_n   <= 1'b0;
               h      <= 1'b0;
               st     <= ST_CMD;
            end
            ST_CMD, ST_ADDR: begin
               h <= !h;
               if (h) begin
                  if (cyc != '0) begin
                     cyc <= cyc - 1'b1;
                  end else begin
                     st    <= phase_nxt;
                     cyc   <= len_q[ALEN_LSB +: LFLD_W];
                     dbits <= 4'd8;
                     have  <= 1'b0;
                     bytes_left <= cnt_q;
                  end
               end
            end
            ST_WDAT, ST_RDAT: begin
               if (!h) begin
                  if (st == ST_RDAT || have) h <= 1'b1;
                  else if (wr_valid)         have <= 1'b1;
               end else begin
                  h <= 1'b0;
                  if (data_last) begin
                     dbits <= 4'd8;
                     have  <= 1'b0;
                     if (bytes_left <= 1) st <= ST_TAIL;
                     else                 bytes_left <= bytes_left - 1'b1;
                  end else begin
                     dbits <= dbits - 4'(dw_n);
                  end
               end
            end
            default: begin
               cs_n <= 1'b1;
               done <= 1'b1;
               st   <= ST_IDLE;
            end
         endcase
      end
   end

   assign sck    = h;
   assign busy   = (st != ST_IDLE);
   assign io_out = sh_lanes & lane_mask(cur_n);
   assign io_oe  = ((st == ST_WDAT) || ((st == ST_CMD || st == ST_ADDR) && sh_active))
                   ? lane_mask(cur_n) : 4'h0;

   // R11
   sck_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sck |-> !cs_n);

   // R11
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sck) |-> ($stable(io_out) && $stable(io_oe)));

   // R8
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ready && !wr_valid) |=> (!sck && !cs_n));

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   cs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> done);

   // R7
   rd_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (io_oe == 4'h0));

endmodule

// File: tb/tb_sflash_seq.sv
`timescale 1ns/1ps
module tb_sflash_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [10:0] ctrl_word = '0;
   logic [11:0] len_word = '0;
   logic [7:0]  opcode = '0;
   logic [23:0] address = '0;
   logic [7:0]  byte_cnt = '0;
   logic [7:0]  wr_data = '0;
   logic        wr_valid = 1'b0;
   logic        wr_ready;
   logic [7:0]  rd_data;
   logic        rd_valid;
   logic        busy, done, cs_n, sck;
   logic [3:0]  io_out, io_oe;
   logic [3:0]  io_in = '0;

   always #2.5 clk = ~clk;

   sflash_seq #(.ADDR_W(24), .CNT_W(8)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .ctrl_word(ctrl_word),
      .len_word(len_word), .opcode(opcode), .address(address),
      .byte_cnt(byte_cnt), .wr_data(wr_data), .wr_valid(wr_valid),
      .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid),
      .busy(busy), .done(done), .cs_n(cs_n), .sck(sck),
      .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
   );

   int n_chk = 0, n_fail = 0;
   int ncyc = 0, rises = 0, done_n = 0, rd_n = 0;
   int first_rise_cyc = 0, last_fall_cyc = 0, cs_fall_cyc = 0, cs_rise_cyc = 0, done_cyc = 0;
   logic [3:0] cap_oe [0:255];
   logic [3:0] cap_out[0:255];
   logic [7:0] rd_buf [0:7];
   logic sck_prev = 1'b0, cs_prev = 1'b1, fire = 1'b0;
   int  rd_base = 0, rd_L = 1, wr_idx = 0, wr_nb = 0;
   bit  rd_on = 0, wr_en = 0;
   int  seed = 0;

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int lof(input int code);
      return (code == 3) ? 4 : (code == 2) ? 2 : 1;
   endfunction

   function automatic logic [3:0] mof(input int L);
      return (L == 4) ? 4'hF : (L == 2) ? 4'h3 : 4'h1;
   endfunction

   // lane pattern of clock c for an nbits-wide value, MSB first, earliest bit on the top lane
   function automatic logic [3:0] lanes_of(input logic [31:0] v, input int nbits, input int L, input int c);
      logic [3:0] o = '0;
      for (int l = 0; l < L; l++) begin
         int p = c * L + (L - 1 - l);
         if (p < nbits) o[l] = v[nbits - 1 - p];
      end
      return o;
   endfunction

   function automatic logic [7:0] rpat(input int i);
      return 8'(8'hA5 ^ (i * 37 + seed * 11));
   endfunction

   function automatic logic [7:0] wpat(input int i);
      return 8'(8'h3C + i * 71 + seed * 5);
   endfunction

   function automatic logic [3:0] drive_in(input int r);
      int j, per;
      logic [3:0] v;
      if (!rd_on || r < rd_base) return 4'h0;
      j   = r - rd_base;
      per = 8 / rd_L;
      v   = lanes_of({24'h0, rpat(j / per)}, 8, rd_L, j % per);
      return (rd_L == 1) ? {2'b00, v[0], 1'b0} : v;
   endfunction

   always @(posedge clk) fire <= wr_valid && wr_ready;

   // observer and flash-side stimulus, away from the active edge
   always @(negedge clk) begin
      ncyc++;
      if (ncyc > 190000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", ncyc, 190000);
         report();
      end
      if (sck && !sck_prev) begin
         if (rises < 256) begin cap_oe[rises] = io_oe; cap_out[rises] = io_out; end
         if (rises == 0) first_rise_cyc = ncyc;
         rises++;
      end
      if (!sck && sck_prev) last_fall_cyc = ncyc;
      if (!cs_n && cs_prev) cs_fall_cyc = ncyc;
      if (cs_n && !cs_prev) cs_rise_cyc = ncyc;
      if (done) begin done_n++; done_cyc = ncyc; end
      if (rd_valid) begin
         if (rd_n < 8) rd_buf[rd_n] = rd_data;
         rd_n++;
      end
      sck_prev = sck;
      cs_prev  = cs_n;
      io_in    = drive_in(rises);
      if (fire) wr_idx++;
      wr_valid = wr_en && (wr_idx < wr_nb) && (ncyc % 3 != 0);
      wr_data  = wpat(wr_idx);
   end

   task automatic run_txn(input int cwc, input int awc, input int dwc, input int cs,
                          input int as, input int it);
      int Lc = lof(cwc), La = lof(awc), Ld = lof(dwc);
      int clen = 8 / Lc - 1 + ((as == 3) ? 1 : 0);
      int alen = 24 / La - 1 + (((cs + as) % 2) * 4);
      int nb   = 1 + (it % 3);
      bit has_a = (cs == 3);
      int kind  = (cs == 5) ? 1 : (cs == 6) ? 2 : (has_a && as == 1) ? 1 : (has_a && as == 2) ? 2 : 0;
      int exp_n, k, mis, guard;
      logic [7:0]  op = 8'(8'h0B + it * 13);
      logic [23:0] ad = 24'h5A3C1E ^ 24'(it * 24'h010203);
      logic [3:0]  eo;

      @(posedge clk); #1;
      seed = it;
      rises = 0; done_n = 0; rd_n = 0; wr_idx = 0;
      rd_base = (clen + 1) + (has_a ? alen + 1 : 0);
      rd_L = Ld; rd_on = (kind == 2);
      wr_en = (kind == 1); wr_nb = nb;
      ctrl_word = {3'(cs), 2'(as), 2'(cwc), 2'(awc), 2'(dwc)};
      len_word  = {6'(clen), 6'(alen)};
      opcode = op; address = ad;
      byte_cnt = (nb == 1 && (it % 2 == 1)) ? 8'd0 : 8'(nb);
      start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
      chk(busy == 1'b1 && cs_n == 1'b0, "R10 busy and chip select after start", busy, 1);
      guard = 0;
      while (done_n == 0 && guard < 2000) begin
         @(posedge clk); #1;
         guard++;
         // R12: a second start while busy must not disturb the frame
         if (guard == 3 && busy) begin
            start = 1'b1; ctrl_word = 11'h7FF; len_word = 12'hFFF; opcode = 8'hFF;
         end else begin
            start = 1'b0;
         end
      end
      start = 1'b0;
      repeat (3) @(posedge clk);
      #1;

      exp_n = (clen + 1) + (has_a ? alen + 1 : 0) + ((kind != 0) ? nb * 8 / Ld : 0);
      chk(rises == exp_n, "R3 R4 R5 R12 serial clock edge count", rises, exp_n);
      chk(done_n == 1, "R10 R12 single done pulse", done_n, 1);
      chk(cs_n == 1'b1 && busy == 1'b0 && sck == 1'b0, "R11 idle after frame", {cs_n, busy, sck}, 3'b100);
      chk(first_rise_cyc - cs_fall_cyc == 1, "R10 chip select lead", first_rise_cyc - cs_fall_cyc, 1);
      chk(cs_rise_cyc - last_fall_cyc == 1 && done_cyc == cs_rise_cyc,
          "R10 chip select trail and done", cs_rise_cyc - last_fall_cyc, 1);

      if (rises == exp_n) begin
         k = 0; mis = 0;
         for (int c = 0; c <= clen; c++) begin
            eo = (c * Lc < 8) ? mof(Lc) : 4'h0;
            if (cap_oe[k] != eo || ((cap_out[k] & eo) != (lanes_of({24'h0, op}, 8, Lc, c) & eo))) mis++;
            k++;
         end
         chk(mis == 0, "R1 R2 R6 opcode lanes and dummy float", mis, 0);
         if (has_a) begin
            mis = 0;
            for (int c = 0; c <= alen; c++) begin
               eo = (c * La < 24) ? mof(La) : 4'h0;
               if (cap_oe[k] != eo || ((cap_out[k] & eo) != (lanes_of({8'h0, ad}, 24, La, c) & eo))) mis++;
               k++;
            end
            chk(mis == 0, "R1 R6 address lanes and dummy float", mis, 0);
         end
         if (kind == 1) begin
            mis = 0;
            for (int j = 0; j < nb * 8 / Ld; j++) begin
               eo = mof(Ld);
               if (cap_oe[k] != eo || cap_out[k] != lanes_of({24'h0, wpat(j / (8 / Ld))}, 8, Ld, j % (8 / Ld))) mis++;
               k++;
            end
            chk(mis == 0, "R8 write lanes", mis, 0);
         end
         if (kind == 2) begin
            mis = 0;
            for (int j = 0; j < nb * 8 / Ld; j++) begin
               if (cap_oe[k] != 4'h0) mis++;
               k++;
            end
            chk(mis == 0, "R7 read phase floats", mis, 0);
         end
      end
      if (kind == 1)
         chk(wr_idx == nb, "R8 R9 write bytes consumed", wr_idx, nb);
      if (kind == 2) begin
         chk(rd_n == nb, "R7 R9 read byte count", rd_n, nb);
         mis = 0;
         for (int j = 0; j < nb && j < 8; j++) if (rd_buf[j] != rpat(j)) mis++;
         chk(mis == 0, "R7 read byte values", mis, 0);
      end
      if (kind == 0)
         chk(rd_n == 0 && wr_idx == 0, "R3 R4 no data phase", rd_n + wr_idx, 0);
      rd_on = 0; wr_en = 0;
   endtask

   initial begin
      int it = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;
      chk(cs_n == 1'b1 && sck == 1'b0 && io_oe == 4'h0 && busy == 1'b0 && done == 1'b0 && wr_ready == 1'b0,
          "R10 reset state", {cs_n, sck, io_oe, busy, done, wr_ready}, 9'b100000000);
      for (int cwc = 1; cwc <= 3; cwc++)
         for (int code = 0; code <= 3; code++)
            for (int cs = 0; cs <= 7; cs++)
               for (int as = 0; as <= 3; as++) begin
                  run_txn(cwc, code, (code + cwc) % 4, cs, as, it);
                  it++;
               end
      report();
   end

endmodule